// File: doc/BRIEF.md
# Rate-Multiplied PWM Generator

This block drives several PWM pins, each with 8 bits of duty resolution, while its counter is only 5 bits wide. Each channel's 8-bit duty word splits into two fields. The upper five bits set a base high time within a 32-tick cycle. The lower three bits decide in how many cycles of an 8-cycle frame the high time grows by one extra tick. The repetition rate is therefore tick/32 rather than tick/256. Averaged over a frame, the high time equals the whole 8-bit duty value, which suits a simple RC-filtered DAC.

All channels share one prescaler, one cycle counter and one frame counter. The tick rate is the system clock divided by 2, 4, 8 or 16, chosen by a 2-bit select. Duty words are level inputs, not a stream. Each channel copies its duty word into a working register only at the end of a frame, so there is no valid/ready handshake and no back-pressure: a value held on the input when a frame ends takes effect for the next whole frame. Per-channel enables are also plain levels, and they act at once.

Top module: `dither_pwm`

## Requirements
- R1: The internal tick occurs once every 2^(SEL+1) system clocks, where SEL is `div_sel_i` (0 gives 2 clocks, 3 gives 16). The prescaler restarts from zero after each tick.
- R2: A PWM cycle lasts 32 ticks. Within a cycle, an enabled channel's pin is high while the 5-bit tick position is below the width field (duty bits 7:3), and low otherwise. A width of 0 gives no base pulse.
- R3: A frame is 8 consecutive cycles, indexed 0 to 7. Cycle k of a frame gets one extra high tick, directly after the base pulse, when the bit-reversed 3-bit value of k is less than the rate field (duty bits 2:0). For example, a rate of 4 selects cycles 0, 2, 4 and 6.
- R4: Over one frame of 256 ticks, an enabled channel is high for exactly as many ticks as its 8-bit duty value (8×width + rate).
- R5: A channel copies its duty input into its working register only at the final tick of a frame. A change during a frame does not alter that frame's waveform.
- R6: While a channel's enable is 0, its pin is low in the same cycle, whatever the duty. Re-enabling restores the waveform at once.
- R7: During reset all pins are low and all counters and working duty registers clear to zero. The first frame after reset is therefore idle on every channel.
- R8: Channels are independent. One channel's duty or enable never changes another channel's pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | SEL_BITS | Tick divider select, ratio 2^(value+1) |
| chan_en_i | input | CHANNELS | Per-channel enable, bit c for channel c |
| duty_i | input | CHANNELS*(PW_BITS+BRM_BITS) | Duty words, channel c in bits [8c+7:8c] |
| pwm_o | output | CHANNELS | PWM pins, bit c for channel c |

## Verification
On every cycle, the assertions check several timing rules:
- the prescaler counts up and restarts after each tick;
- the cycle counter advances only on a tick;
- the frame index steps only when a cycle wraps;
- the working duty registers stay unchanged except at a frame end;
- no disabled channel ever drives its pin high.

Some behaviour only the bench scenarios can show:
- the exact waveform shape;
- the placement of the extra ticks by bit-reversed cycle index;
- the 256-tick high count equal to the duty value under each divider setting;
- that a duty change in the middle of a frame is deferred to the next frame.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // Default geometry shared by the generator and its checker
  localparam int unsigned CHANNELS_DEF = 5;
  localparam int unsigned PW_BITS_DEF  = 5;
  localparam int unsigned BRM_BITS_DEF = 3;
  localparam int unsigned SEL_BITS_DEF = 2;
endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler #(
  parameter int unsigned SEL_BITS = 2,
  localparam int unsigned CNT_W = 1 << SEL_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_BITS-1:0] sel_i,
  output logic                tick_o,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] limit;

  // ratio = 2^(sel+1); the select is widened so that the top code does not wrap
  always_comb begin
    ratio  = (CNT_W+1)'(1) << ({1'b0, sel_i} + 1'b1);
    limit  = CNT_W'(ratio - 1'b1);
    // >= keeps the count bounded if the select drops mid-count
    tick_o = (cnt_q >= limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int unsigned PW_BITS  = 5,
  parameter int unsigned BRM_BITS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  output logic [PW_BITS-1:0]  cyc_o,
  output logic [BRM_BITS-1:0] frame_o,
  output logic                frame_end_o
);
  logic [PW_BITS-1:0]  cyc_q;
  logic [BRM_BITS-1:0] frame_q;
  logic                cycle_end;

  assign cycle_end   = tick_i & (&cyc_q);
  assign frame_end_o = cycle_end & (&frame_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      frame_q <= '0;
    end else if (tick_i) begin
      cyc_q <= cyc_q + 1'b1;
      if (cycle_end) frame_q <= frame_q + 1'b1;
    end
  end

  assign cyc_o   = cyc_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int unsigned PW_BITS  = 5,
  parameter int unsigned BRM_BITS = 3,
  localparam int unsigned DUTY_W  = PW_BITS + BRM_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                en_i,
  input  logic [DUTY_W-1:0]   duty_i,
  input  logic [PW_BITS-1:0]  cyc_i,
  input  logic [BRM_BITS-1:0] frame_i,
  output logic [DUTY_W-1:0]   duty_q_o,
  output logic                pwm_o
);
  logic [DUTY_W-1:0]   duty_q;
  logic [PW_BITS-1:0]  width;
  logic [BRM_BITS-1:0] rate;
  logic [BRM_BITS-1:0] slot;
  logic                extra;
  logic [PW_BITS:0]    hi_lim;

  // The working duty changes only on the last tick of a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (load_i) duty_q <= duty_i;
  end

  // The bit-reversed frame index spreads the extra ticks evenly
  for (genvar b = 0; b < BRM_BITS; b++) begin : g_rev
    assign slot[b] = frame_i[BRM_BITS-1-b];
  end

  always_comb begin
    width  = duty_q[DUTY_W-1:BRM_BITS];
    rate   = duty_q[BRM_BITS-1:0];
    extra  = (slot < rate);
    hi_lim = {1'b0, width} + {{PW_BITS{1'b0}}, extra};
    pwm_o  = en_i & ({1'b0, cyc_i} < hi_lim);
  end

  assign duty_q_o = duty_q;
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned CHANNELS = CHANNELS_DEF,
  parameter int unsigned PW_BITS  = PW_BITS_DEF,
  parameter int unsigned BRM_BITS = BRM_BITS_DEF,
  parameter int unsigned SEL_BITS = SEL_BITS_DEF,
  localparam int unsigned DUTY_W  = PW_BITS + BRM_BITS,
  localparam int unsigned CNT_W   = 1 << SEL_BITS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SEL_BITS-1:0]        div_sel_i,
  input  logic [CHANNELS-1:0]        chan_en_i,
  input  logic [CHANNELS*DUTY_W-1:0] duty_i,
  output logic [CHANNELS-1:0]        pwm_o
);
  logic                       tick_w;
  logic [CNT_W-1:0]           pre_cnt_w;
  logic [PW_BITS-1:0]         cyc_w;
  logic [BRM_BITS-1:0]        frame_w;
  logic                       frame_end_w;
  logic [CHANNELS*DUTY_W-1:0] duty_held_w;

  dpwm_prescaler #(.SEL_BITS(SEL_BITS)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (div_sel_i),
    .tick_o(tick_w),
    .cnt_o (pre_cnt_w)
  );

  dpwm_timebase #(.PW_BITS(PW_BITS), .BRM_BITS(BRM_BITS)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .cyc_o      (cyc_w),
    .frame_o    (frame_w),
    .frame_end_o(frame_end_w)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    dpwm_channel #(.PW_BITS(PW_BITS), .BRM_BITS(BRM_BITS)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (frame_end_w),
      .en_i    (chan_en_i[c]),
      .duty_i  (duty_i[c*DUTY_W +: DUTY_W]),
      .cyc_i   (cyc_w),
      .frame_i (frame_w),
      .duty_q_o(duty_held_w[c*DUTY_W +: DUTY_W]),
      .pwm_o   (pwm_o[c])
    );
  end
endmodule

// File: rtl/dither_pwm_chk.sv
module dither_pwm_chk #(
  parameter int unsigned CHANNELS = 5,
  parameter int unsigned PW_BITS  = 5,
  parameter int unsigned BRM_BITS = 3,
  parameter int unsigned SEL_BITS = 2,
  localparam int unsigned DUTY_W  = PW_BITS + BRM_BITS,
  localparam int unsigned CNT_W   = 1 << SEL_BITS
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [CHANNELS-1:0]        chan_en_i,
  input logic [CHANNELS-1:0]        pwm_o,
  input logic                       tick,
  input logic [CNT_W-1:0]           pre_cnt,
  input logic [PW_BITS-1:0]         cyc,
  input logic [BRM_BITS-1:0]        frame,
  input logic                       frame_end,
  input logic [CHANNELS*DUTY_W-1:0] duty_held
);
  p_presc_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> pre_cnt == '0);

  p_presc_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> pre_cnt == CNT_W'($past(pre_cnt) + 1'b1));

  p_cyc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cyc));

  p_cyc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> cyc == PW_BITS'($past(cyc) + 1'b1));

  p_frame_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (&cyc)) |=> frame == BRM_BITS'($past(frame) + 1'b1));

  p_frame_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick && (&cyc)) |=> $stable(frame));

  p_duty_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(duty_held));

  p_disabled_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~chan_en_i) == '0);
endmodule

bind dither_pwm dither_pwm_chk #(
  .CHANNELS(CHANNELS), .PW_BITS(PW_BITS), .BRM_BITS(BRM_BITS), .SEL_BITS(SEL_BITS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .chan_en_i(chan_en_i),
  .pwm_o    (pwm_o),
  .tick     (tick_w),
  .pre_cnt  (pre_cnt_w),
  .cyc      (cyc_w),
  .frame    (frame_w),
  .frame_end(frame_end_w),
  .duty_held(duty_held_w)
);

// File: tb/sim_dither_pwm.sv
module sim_dither_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 5;
  localparam int NVEC = 6;

  // {sel[1:0], en[4:0], duty4, duty3, duty2, duty1, duty0}
  localparam logic [46:0] VEC [NVEC] = '{
    {2'd0, 5'h1F, 8'h7F, 8'hFF, 8'h80, 8'h01, 8'h00},
    {2'd1, 5'h1F, 8'h10, 8'hC3, 8'h3C, 8'h04, 8'h08},
    {2'd3, 5'h1F, 8'h20, 8'hF8, 8'h07, 8'hAA, 8'h55},
    {2'd2, 5'h0A, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90},
    {2'd0, 5'h15, 8'h99, 8'h40, 8'h02, 8'hE0, 8'h1F},
    {2'd1, 5'h1F, 8'h05, 8'h06, 8'h11, 8'h81, 8'hFE}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    div_sel = '0;
  logic [CH-1:0] en = '0;
  logic [39:0]   duty = '0;
  logic [CH-1:0] pwm;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_pwm u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .div_sel_i(div_sel),
    .chan_en_i(en),
    .duty_i   (duty),
    .pwm_o    (pwm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rev3(input int k);
    return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
  endfunction

  // Expected pin level for sample j after reset release with effective duty d
  function automatic bit exp_hi(input int j, input int r, input int d, input bit e);
    int t;
    int k;
    t = (j / r) % 32;
    k = (j / (32 * r)) % 8;
    return e && (t < ((d >> 3) + ((rev3(k) < (d & 7)) ? 1 : 0)));
  endfunction

  task automatic release_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vector(input logic [46:0] v);
    int r;
    int f0[CH];
    int f1[CH];
    int mis[CH];
    r = 2 << v[46:45];
    rst_n = 1'b0;
    div_sel = v[46:45];
    en = v[44:40];
    duty = v[39:0];
    for (int c = 0; c < CH; c++) begin
      f0[c] = 0;
      f1[c] = 0;
      mis[c] = 0;
    end
    release_reset();
    for (int j = 0; j < 512 * r; j++) begin
      for (int c = 0; c < CH; c++) begin
        int d;
        d = (j < 256 * r) ? 0 : int'(v[c*8 +: 8]);
        if (pwm[c]) begin
          if (j < 256 * r) f0[c]++;
          else f1[c]++;
        end
        if (pwm[c] !== exp_hi(j, r, d, en[c])) mis[c]++;
      end
      @(negedge clk);
    end
    for (int c = 0; c < CH; c++) begin
      int d;
      d = en[c] ? int'(v[c*8 +: 8]) : 0;
      check(f0[c] == 0, "R7 first frame idle", f0[c], 0);
      check(f1[c] == r * d, "R4/R1/R6/R8 frame high count", f1[c], r * d);
      check(mis[c] == 0, "R2/R3 waveform mismatches", mis[c], 0);
    end
  endtask

  initial begin
    // R7: reset holds every pin low even with full duty and enables
    rst_n = 1'b0;
    en = '1;
    duty = {5{8'hFF}};
    repeat (4) @(negedge clk);
    check(pwm == '0, "R7 pins low in reset", int'(pwm), 0);

    for (int i = 0; i < NVEC; i++) run_vector(VEC[i]);

    // R5: duty change in the middle of frame 1 takes effect only in frame 2
    begin
      int r;
      int cnt[3];
      int mis;
      r = 2;
      mis = 0;
      cnt = '{0, 0, 0};
      rst_n = 1'b0;
      div_sel = 2'd0;
      en = '1;
      duty = {5{8'h40}};
      release_reset();
      for (int j = 0; j < 768 * r; j++) begin
        int d;
        if (j == 256 * r + 200) duty[7:0] = 8'hC5;
        d = (j < 256 * r) ? 0 : ((j < 512 * r) ? 8'h40 : 8'hC5);
        if (pwm[0]) cnt[j / (256 * r)]++;
        if (pwm[0] !== exp_hi(j, r, d, 1'b1)) mis++;
        @(negedge clk);
      end
      check(cnt[1] == r * 8'h40, "R5 old duty kept for current frame", cnt[1], r * 8'h40);
      check(cnt[2] == r * 8'hC5, "R5 new duty in next frame", cnt[2], r * 8'hC5);
      check(mis == 0, "R5 waveform around latch", mis, 0);
    end

    // R6/R8: enable drop acts at once and leaves other channels alone
    begin
      int r;
      int hi;
      r = 4;
      hi = 0;
      rst_n = 1'b0;
      div_sel = 2'd1;
      en = '1;
      duty = {8'h80, 8'h80, 8'hFF, 8'h80, 8'h80};
      release_reset();
      repeat (256 * r + 4) @(negedge clk);
      check(pwm[2] == 1'b1, "R6 enabled pin high", int'(pwm[2]), 1);
      en[2] = 1'b0;
      #1;
      check(pwm[2] == 1'b0, "R6 pin low at once", int'(pwm[2]), 0);
      check(pwm[4] == 1'b1, "R8 neighbour unaffected", int'(pwm[4]), 1);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pwm[2]) hi++;
      end
      check(hi == 0, "R6 disabled pin stays low", hi, 0);
      en[2] = 1'b1;
      #1;
      check(pwm[2] == 1'b1, "R6 re-enable restores pin", int'(pwm[2]), 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule